// File: doc/BRIEF.md
# Serial Peripheral Master with Late Read Capture

This block is a single-master serial peripheral bus controller. It shifts a byte out on the serial data output and collects a byte from the serial data input, while driving the serial clock and one active-low select line per attached device. The internal clock runs at twice the serial clock rate, so every serial clock edge falls on an internal clock edge. All bus pins are registered, including the incoming data line.

At high bus rates a slow device, or long traces, can push the returned data past the edge that would normally capture it. The block therefore takes a small delay setting with each request. The setting moves the capture of each incoming bit later by whole half-periods of the serial clock. The outgoing data and the clock waveform stay exactly the same. After the last clock edge the select is held low for as many extra half-periods as the delay setting, so the trailing bits are still collected.

A request is a one-cycle start strobe carrying the byte to send, the device index and the delay. The block reports busy while a transfer runs. A one-cycle done pulse marks the point at which the received byte is valid on its output register.

Top module: `spi_dly_master`

## Requirements
- R1: While reset is applied and after it is released, all selects are high, the serial clock is low, the data output is low, busy and done are low and the received byte is zero.
- R2: A start strobe is taken only while busy is low. A strobe during a transfer changes neither the device being addressed, the data sent, the delay in use nor the transfer length.
- R3: From the accepted start until the end of the transfer, only the select whose index was given at start is low. All other selects stay high, and at most one select is ever low.
- R4: The serial clock idles low and gives exactly 8 rising edges per transfer. Each high or low phase lasts one internal clock cycle.
- R5: The byte is sent most significant bit first. The data output is set up when the start is accepted and changes afterwards only together with a falling serial clock edge, so it is stable at every rising edge.
- R6: With delay 0, each incoming bit is taken at the rising serial clock edge at which the device is expected to hold it.
- R7: With delay d (0 to 3), each incoming bit is taken d half-periods after the rising edge of R6. A device whose output lags by more than half a period is read wrongly with delay 0 and correctly with a suitable larger delay.
- R8: Busy stays high for 17 + d internal cycles per transfer. This is one set-up cycle, 16 clock phases and d trailing cycles, during which the select is low and the clock is low. When done is high, every select is high and the clock is low.
- R9: Done is high for exactly one cycle. It rises 18 + d cycles after the cycle in which start was driven. The received byte changes only together with done and holds its value until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle transfer request |
| tx_data_i | input | DATA_W | Byte to send, sampled with the start |
| sel_i | input | SEL_W | Device index, sampled with the start |
| dly_i | input | DLY_W | Capture delay in half-periods, sampled with the start |
| miso_i | input | 1 | Serial data from the devices |
| busy_o | output | 1 | High while a transfer runs |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rx_data_o | output | DATA_W | Last received byte |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the devices |
| cs_n_o | output | NUM_SLAVES | Active-low device selects |

## Verification
The assertions assume that a request carries a device index below the number of selects and a delay no larger than the supported maximum. They also assume that reset is held for at least one clock edge before the first request. The directed tests drive only legal indices and delays, always from the falling internal clock edge. They raise extra start strobes only in the middle of a transfer, where R2 says they must be ignored. The device model changes its output only at times well away from internal clock edges, so the late capture is judged against the device delay and not against race ordering.

// File: rtl/spi_dly_pkg.sv
`timescale 1ns/1ps
// Shared types for the late-capture serial master.
// Assumes: nothing beyond a synthesizable package.
package spi_dly_pkg;

    // Sequencer phases of one transfer
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } seq_st_e;

endpackage

// File: rtl/spi_dly_seq.sv
`timescale 1ns/1ps
// Transfer sequencer: accepts a request, drives the serial clock and the
// selects, and emits phase strobes for the send and receive paths.
// Assumes: sel_i < NUM_SLAVES and dly_i <= MAX_DLY when start_i is high.
module spi_dly_seq
    import spi_dly_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_SLAVES = 4,
    parameter int MAX_DLY    = 3,
    localparam int HALF_N    = 2 * DATA_W,
    localparam int HW        = $clog2(HALF_N),
    localparam int DLY_W     = $clog2(MAX_DLY + 1),
    localparam int SEL_W     = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [SEL_W-1:0]      sel_i,
    input  logic [DLY_W-1:0]      dly_i,
    output logic                  busy_o,
    output logic                  load_o,
    output logic                  rise_o,
    output logic                  fall_o,
    output logic                  last_rise_o,
    output logic [DLY_W-1:0]      dly_o,
    output logic                  sclk_o,
    output logic [NUM_SLAVES-1:0] cs_n_o
);

    seq_st_e          state_q;
    logic [HW-1:0]    half_q;
    logic [DLY_W-1:0] tail_q;
    logic [DLY_W-1:0] dly_q;
    logic             shift_last;
    logic             end_xfer;

    // Decode phase strobes from the current state
    always_comb begin
        load_o      = (state_q == ST_IDLE) && start_i;
        rise_o      = (state_q == ST_SHIFT) && !half_q[0];
        fall_o      = (state_q == ST_SHIFT) && half_q[0];
        last_rise_o = (state_q == ST_SHIFT) && (half_q == HW'(HALF_N - 2));
        shift_last  = (state_q == ST_SHIFT) && (half_q == HW'(HALF_N - 1));
        end_xfer    = (shift_last && (dly_q == '0)) ||
                      ((state_q == ST_TAIL) && (tail_q == dly_q - 1'b1));
        busy_o      = (state_q != ST_IDLE);
        dly_o       = dly_q;
    end

    // Phase state machine with half-period and trailing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            half_q  <= '0;
            tail_q  <= '0;
            dly_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_LEAD;
                        dly_q   <= dly_i;
                    end
                end
                ST_LEAD: begin
                    state_q <= ST_SHIFT;
                    half_q  <= '0;
                end
                ST_SHIFT: begin
                    half_q <= half_q + 1'b1;
                    if (shift_last) begin
                        tail_q  <= '0;
                        state_q <= (dly_q == '0) ? ST_IDLE : ST_TAIL;
                    end
                end
                default: begin
                    tail_q <= tail_q + 1'b1;
                    if (end_xfer) state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Serial clock register: toggles once per cycle while shifting
    always_ff @(posedge clk) begin
        if (!rst_n)                    sclk_o <= 1'b0;
        else if (state_q == ST_SHIFT)  sclk_o <= ~sclk_o;
        else                           sclk_o <= 1'b0;
    end

    // One select register per device
    for (genvar gi = 0; gi < NUM_SLAVES; gi++) begin : g_cs
        always_ff @(posedge clk) begin
            if (!rst_n)                                     cs_n_o[gi] <= 1'b1;
            else if (load_o && (sel_i == SEL_W'(gi)))      cs_n_o[gi] <= 1'b0;
            else if (end_xfer)                              cs_n_o[gi] <= 1'b1;
        end
    end

    // R3
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R4
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_o);

    // R2
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !end_xfer) |=> ($stable(cs_n_o) && $stable(dly_q) && busy_o));

    // R8
    busy_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !(&cs_n_o));

endmodule

// File: rtl/spi_dly_tx.sv
`timescale 1ns/1ps
// Send path: loads the byte at start and shifts it out MSB first,
// advancing on each falling serial clock strobe.
// Assumes: fall_i only pulses while a transfer is running.
module spi_dly_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              fall_i,
    output logic              mosi_o
);

    logic [DATA_W-2:0] tx_sh;

    // Output register and remaining-bit shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            mosi_o <= 1'b0;
        end else if (load_i) begin
            tx_sh  <= data_i[DATA_W-2:0];
            mosi_o <= data_i[DATA_W-1];
        end else if (fall_i) begin
            tx_sh  <= {tx_sh[DATA_W-3:0], 1'b0};
            mosi_o <= tx_sh[DATA_W-2];
        end
    end

endmodule

// File: rtl/spi_dly_rx.sv
`timescale 1ns/1ps
// Receive path: registers the input pin, delays the rising-edge strobe
// by the chosen number of half-periods, and assembles the byte.
// Assumes: dly_i is held for the whole transfer and is <= MAX_DLY.
module spi_dly_rx #(
    parameter int DATA_W  = 8,
    parameter int MAX_DLY = 3,
    localparam int DLY_W  = $clog2(MAX_DLY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miso_i,
    input  logic              rise_i,
    input  logic              last_rise_i,
    input  logic [DLY_W-1:0]  dly_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              done_o
);

    logic               miso_q;
    logic [MAX_DLY:0]   stb_q;
    logic [MAX_DLY:0]   lst_q;
    logic [DATA_W-2:0]  rx_sh;
    logic               cap;
    logic               fin;

    // Input pin register
    always_ff @(posedge clk) begin
        if (!rst_n) miso_q <= 1'b0;
        else        miso_q <= miso_i;
    end

    // Strobe delay line, tap 0 aligns with the registered pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= '0;
            lst_q <= '0;
        end else begin
            stb_q[0] <= rise_i;
            lst_q[0] <= last_rise_i;
            for (int i = 1; i <= MAX_DLY; i++) begin
                stb_q[i] <= stb_q[i-1];
                lst_q[i] <= lst_q[i-1];
            end
        end
    end

    // Select the tap for the chosen delay
    always_comb begin
        cap = stb_q[dly_i];
        fin = lst_q[dly_i];
    end

    // Assemble bits and publish the byte on the final capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh     <= '0;
            rx_data_o <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (cap) rx_sh <= {rx_sh[DATA_W-3:0], miso_q};
            if (fin) begin
                rx_data_o <= {rx_sh, miso_q};
                done_o    <= 1'b1;
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data_o) |-> done_o);

endmodule

// File: rtl/spi_dly_master.sv
`timescale 1ns/1ps
// Top level: serial bus master whose read capture point can be moved
// later in half-period steps. Wires sequencer, send and receive paths.
// Assumes: clk is twice the wanted serial clock rate; requests obey the
// index and delay ranges of the parameters.
module spi_dly_master #(
    parameter int DATA_W     = 8,
    parameter int NUM_SLAVES = 4,
    parameter int MAX_DLY    = 3,
    localparam int DLY_W     = $clog2(MAX_DLY + 1),
    localparam int SEL_W     = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [DATA_W-1:0]     tx_data_i,
    input  logic [SEL_W-1:0]      sel_i,
    input  logic [DLY_W-1:0]      dly_i,
    input  logic                  miso_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [DATA_W-1:0]     rx_data_o,
    output logic                  sclk_o,
    output logic                  mosi_o,
    output logic [NUM_SLAVES-1:0] cs_n_o
);

    logic             load_s;
    logic             rise_s;
    logic             fall_s;
    logic             last_rise_s;
    logic [DLY_W-1:0] dly_s;

    spi_dly_seq #(
        .DATA_W     (DATA_W),
        .NUM_SLAVES (NUM_SLAVES),
        .MAX_DLY    (MAX_DLY)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .sel_i       (sel_i),
        .dly_i       (dly_i),
        .busy_o      (busy_o),
        .load_o      (load_s),
        .rise_o      (rise_s),
        .fall_o      (fall_s),
        .last_rise_o (last_rise_s),
        .dly_o       (dly_s),
        .sclk_o      (sclk_o),
        .cs_n_o      (cs_n_o)
    );

    spi_dly_tx #(
        .DATA_W (DATA_W)
    ) tx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_s),
        .data_i (tx_data_i),
        .fall_i (fall_s),
        .mosi_o (mosi_o)
    );

    spi_dly_rx #(
        .DATA_W  (DATA_W),
        .MAX_DLY (MAX_DLY)
    ) rx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .miso_i      (miso_i),
        .rise_i      (rise_s),
        .last_rise_i (last_rise_s),
        .dly_i       (dly_s),
        .rx_data_o   (rx_data_o),
        .done_o      (done_o)
    );

    // R5
    mosi_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !$stable(mosi_o)) |-> ($fell(sclk_o) || $rose(busy_o)));

    // R8
    done_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((&cs_n_o) && !sclk_o));

endmodule

// File: tb/spi_dly_master_tb.sv
`timescale 1ns/1ps
// Directed bench: a device model with adjustable output lag answers each
// transfer; every scenario task checks its own results.
module spi_dly_master_tb_top;

    localparam int DATA_W = 8;
    localparam int NSL    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [7:0]       tx_data_i = '0;
    logic [1:0]       sel_i = '0;
    logic [1:0]       dly_i = '0;
    logic             miso_i = 1'b0;
    logic             busy_o;
    logic             done_o;
    logic [7:0]       rx_data_o;
    logic             sclk_o;
    logic             mosi_o;
    logic [NSL-1:0]   cs_n_o;
    wire              cs_all = &cs_n_o;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // device model state
    int         slv_dly = 1;
    logic [7:0] s_byte  = '0;
    int         s_idx   = 0;
    // bus monitors
    int         rise_cnt = 0;
    logic [7:0] mosi_mon = '0;

    always #2.5 clk = ~clk;

    spi_dly_master dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .tx_data_i (tx_data_i),
        .sel_i     (sel_i),
        .dly_i     (dly_i),
        .miso_i    (miso_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .rx_data_o (rx_data_o),
        .sclk_o    (sclk_o),
        .mosi_o    (mosi_o),
        .cs_n_o    (cs_n_o)
    );

    task automatic slv_drive(input logic v);
        fork
            begin
                automatic logic vv = v;
                #(slv_dly);
                miso_i = vv;
            end
        join_none
    endtask

    // device launches first bit on select, next bits on falling clock
    always @(negedge cs_all) begin
        s_idx = DATA_W - 1;
        slv_drive(s_byte[DATA_W-1]);
    end

    always @(negedge sclk_o) begin
        if (!cs_all) begin
            s_idx = s_idx - 1;
            slv_drive((s_idx >= 0) ? s_byte[s_idx] : 1'b0);
        end
    end

    // bus monitor: count rising edges and sample the data output
    always @(posedge sclk_o) begin
        rise_cnt = rise_cnt + 1;
        mosi_mon = {mosi_mon[6:0], mosi_o};
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one transfer; poke_k > 0 raises a stray start in that cycle
    task automatic xfer(input int d, input int sd, input logic [7:0] tx,
                        input logic [7:0] sb, input int sel,
                        input logic [7:0] exp_rx, input string rtag,
                        input int poke_k);
        int busy_cnt = 0;
        int done_k = 0;
        int done_cnt = 0;
        logic [NSL-1:0] seen_low = '0;
        logic [7:0] rx_at_done = '0;
        @(negedge clk);
        slv_dly   = sd;
        s_byte    = sb;
        tx_data_i = tx;
        sel_i     = 2'(sel);
        dly_i     = 2'(d);
        start_i   = 1'b1;
        rise_cnt  = 0;
        mosi_mon  = '0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (k == poke_k) begin
                start_i   = 1'b1;
                tx_data_i = ~tx;
                sel_i     = 2'(sel + 1);
                dly_i     = 2'(3 - d);
            end else begin
                start_i = 1'b0;
            end
            if (busy_o) busy_cnt++;
            if (done_o) begin
                done_cnt++;
                if (done_k == 0) begin
                    done_k = k;
                    rx_at_done = rx_data_o;
                end
            end
            seen_low |= ~cs_n_o;
        end
        chk(rx_data_o == exp_rx, rtag, rx_data_o, exp_rx);
        // R5 send order
        chk(mosi_mon == tx, "R5", mosi_mon, tx);
        // R4 eight rising edges
        chk(rise_cnt == 8, "R4", rise_cnt, 8);
        // R3 only the addressed select went low
        chk(seen_low == NSL'(1 << sel), "R3", seen_low, 1 << sel);
        // R8 busy length
        chk(busy_cnt == 17 + d, "R8", busy_cnt, 17 + d);
        // R9 done timing, width and hold
        chk(done_k == 18 + d, "R9", done_k, 18 + d);
        chk(done_cnt == 1, "R9", done_cnt, 1);
        chk(rx_data_o == rx_at_done, "R9", rx_data_o, rx_at_done);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 values under reset
        chk(cs_n_o == '1 && !sclk_o && !mosi_o, "R1", {cs_n_o, sclk_o, mosi_o}, 6'h3c);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 values after release
        chk(!busy_o && !done_o && rx_data_o == 8'h00, "R1", {busy_o, done_o, rx_data_o}, 0);
        chk(cs_n_o == '1 && !sclk_o, "R1", {cs_n_o, sclk_o}, 5'h1e);
    endtask

    task automatic t_fast_slave();
        // R6: small device lag, no delay, byte read correctly
        xfer(0, 1, 8'hA5, 8'h3C, 0, 8'h3C, "R6", 0);
    endtask

    task automatic t_slow_slave_no_delay();
        // R7: lag above half a period, delay 0 reads the previous bit
        xfer(0, 7, 8'h5A, 8'hA5, 1, {1'b1, 7'(8'hA5 >> 1)}, "R7", 0);
    endtask

    task automatic t_slow_slave_delay1();
        // R7: one half-period later capture recovers the byte
        xfer(1, 7, 8'hC3, 8'hA5, 2, 8'hA5, "R7", 0);
    endtask

    task automatic t_slow_slave_delay2();
        // R7: one full period later capture also recovers it
        xfer(2, 7, 8'h81, 8'h69, 3, 8'h69, "R7", 0);
    endtask

    task automatic t_very_slow_slave();
        // R7: larger lag is too much for delay 1 but fine for delay 3
        xfer(1, 12, 8'h0F, 8'hB4, 0, {1'b1, 7'(8'hB4 >> 1)}, "R7", 0);
        xfer(3, 12, 8'hF0, 8'hB4, 2, 8'hB4, "R7", 0);
    endtask

    task automatic t_busy_start();
        // R2: stray start mid-transfer changes nothing
        xfer(1, 7, 8'h3C, 8'h96, 1, 8'h96, "R2", 5);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fast_slave();
        t_slow_slave_no_delay();
        t_slow_slave_delay1();
        t_slow_slave_delay2();
        t_very_slow_slave();
        t_busy_start();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule